// File: doc/BRIEF.md
# ADC threshold alarm interrupt unit

This unit sits beside an analog-to-digital converter and looks at every finished conversion. It compares an eight-bit magnitude window of each signed result with a programmable upper limit and a programmable lower limit. It then records what happened in sticky status bits and raises one shared interrupt request. Software uses a small register port to set the two limits, to read the status, and to clear status bits by writing ones.

The window under comparison is the eight magnitude bits just below the sign bit of the 16-bit result. The sign bit itself overrides the comparison. When neither alarm is enabled, the unit raises an ordinary end-of-conversion interrupt. Enabling either alarm suppresses that interrupt, so a continuously running converter only disturbs the processor when a sample leaves the window. When the converter is disabled, no new interrupt can start, but one that is already pending stays pending.

Top module: `adc_alarm_top`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge) the upper limit reads 0xFF, the lower limit reads 0x00, all three status bits are 0 and irq is 0.
- R2: On a conversion (conv_done high), the compared value is {sample_hi[6:0], sample_lo[7]}, which is result bits 14:7. If sample_hi[7] is 0, the upper alarm status sets only when this value is strictly greater than the upper limit. Equality does not set it.
- R3: If sample_hi[7] is 1, the conversion always sets the lower alarm status and never sets the upper alarm status. If sample_hi[7] is 0, the lower alarm status sets only when the value is strictly less than the lower limit.
- R4: Every conversion sets the done status bit and evaluates both alarm status bits, whatever the values of adc_en, hi_en and lo_en. Status bits are visible on the outputs in the cycle after conv_done.
- R5: Status bits are sticky. A register write to address 2 clears each status bit whose write-data bit is 1 (bit 0 done, bit 1 upper alarm, bit 2 lower alarm). Zero bits leave the status unchanged. When a set and a clear reach the same bit in the same cycle, the set wins.
- R6: A conversion makes the end-of-conversion interrupt pending only when adc_en is 1 and both hi_en and lo_en are 0.
- R7: A conversion that sets an alarm condition while adc_en and that alarm's enable are both 1 makes that alarm's interrupt pending.
- R8: While adc_en is 0, no conversion makes any interrupt pending. Interrupts already pending stay pending and irq stays asserted.
- R9: irq is the OR of the three pending interrupts. Each pending interrupt clears together with its status bit through a write-1 clear. irq falls in the cycle after the last pending one is cleared.
- R10: Register map: address 0 is the upper limit, address 1 is the lower limit, and address 2 is the status (bits 2:0 as in R5, upper bits zero). Address 3 reads zero. Writes to addresses 0 and 1 take effect for conversions in later cycles. reg_rdata is combinational from reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Converter enabled |
| hi_en | input | 1 | Upper alarm interrupt enable |
| lo_en | input | 1 | Lower alarm interrupt enable |
| conv_done | input | 1 | One-cycle pulse, result bytes valid |
| sample_hi | input | 8 | Result high byte, bit 7 is sign |
| sample_lo | input | 8 | Result low byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Shared interrupt request |
| stat_done | output | 1 | Conversion-done status |
| stat_hi | output | 1 | Upper alarm status |
| stat_lo | output | 1 | Lower alarm status |

## Verification
The bench builds the unit with its default eight-bit bytes and eight-bit limits, so the compared window is result bits 14:7. With these values every limit value from 0x00 to 0xFF can be set, and the exact-equality edges on both sides can be driven directly. These defaults also let a negative sample with an all-ones window be checked against the smallest possible upper limit. A behavioural model in the bench runs next to the unit through directed corner cases and a long stretch of random conversions, enable changes and clears.

// File: rtl/adc_alarm_pkg.sv
package adc_alarm_pkg;

    typedef enum logic [1:0] {
        REG_TH_UP  = 2'd0,
        REG_TH_DN  = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } adc_reg_e;

    // bit order is the status register layout
    typedef struct packed {
        logic dn;
        logic up;
        logic eoc;
    } adc_flags_t;

    localparam int FLAG_N = $bits(adc_flags_t);

endpackage

// File: rtl/adc_alarm_cmp.sv
module adc_alarm_cmp
#(
    parameter int BYTE_W = 8,
    parameter int TH_W   = 8
)
(
    input  logic [BYTE_W-1:0] sample_hi,
    input  logic [BYTE_W-1:0] sample_lo,
    input  logic [TH_W-1:0]   th_up,
    input  logic [TH_W-1:0]   th_dn,
    output logic              over,
    output logic              under
);
    localparam int SAMPLE_W = 2 * BYTE_W;
    localparam int SIGN_B   = SAMPLE_W - 1;
    localparam int WIN_LSB  = SIGN_B - TH_W;

    logic [SAMPLE_W-1:0] sample;
    logic [TH_W-1:0]     window;
    logic                neg;
    logic                unused_low;

    assign sample     = {sample_hi, sample_lo};
    assign neg        = sample[SIGN_B];
    assign window     = sample[SIGN_B-1 -: TH_W];
    assign unused_low = ^sample[WIN_LSB-1:0];

    always_comb begin
        over  = !neg && (window > th_up);
        under = neg || (window < th_dn);
    end
endmodule

// File: rtl/adc_alarm_regs.sv
module adc_alarm_regs
    import adc_alarm_pkg::*;
#(
    parameter int TH_W = 8
)
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic [TH_W-1:0] wdata,
    output logic [TH_W-1:0] th_up,
    output logic [TH_W-1:0] th_dn,
    output adc_flags_t      clr
);
    logic unused_wd;
    assign unused_wd = ^wdata[TH_W-1:FLAG_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            th_up <= '1;
            th_dn <= '0;
        end else if (we) begin
            if (addr == REG_TH_UP) th_up <= wdata;
            if (addr == REG_TH_DN) th_dn <= wdata;
        end
    end

    always_comb begin
        clr = '0;
        if (we && addr == REG_STATUS) clr = adc_flags_t'(wdata[FLAG_N-1:0]);
    end
endmodule

// File: rtl/adc_alarm_sticky.sv
module adc_alarm_sticky
#(
    parameter int N = 3
)
(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_alarm_top.sv
module adc_alarm_top
    import adc_alarm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int TH_W   = 8
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_en,
    input  logic              hi_en,
    input  logic              lo_en,
    input  logic              conv_done,
    input  logic [BYTE_W-1:0] sample_hi,
    input  logic [BYTE_W-1:0] sample_lo,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [TH_W-1:0]   reg_wdata,
    output logic [TH_W-1:0]   reg_rdata,
    output logic              irq,
    output logic              stat_done,
    output logic              stat_hi,
    output logic              stat_lo
);
    logic [TH_W-1:0] th_up, th_dn;
    logic            over, under;
    adc_flags_t      clr, st_set, pd_set, st_q, pd_q;

    adc_alarm_regs #(.TH_W(TH_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .th_up(th_up), .th_dn(th_dn), .clr(clr)
    );

    adc_alarm_cmp #(.BYTE_W(BYTE_W), .TH_W(TH_W)) u_cmp (
        .sample_hi(sample_hi), .sample_lo(sample_lo),
        .th_up(th_up), .th_dn(th_dn), .over(over), .under(under)
    );

    always_comb begin
        st_set.eoc = conv_done;
        st_set.up  = conv_done && over;
        st_set.dn  = conv_done && under;
        pd_set.eoc = conv_done && adc_en && !hi_en && !lo_en;
        pd_set.up  = conv_done && adc_en && hi_en && over;
        pd_set.dn  = conv_done && adc_en && lo_en && under;
    end

    adc_alarm_sticky #(.N(FLAG_N)) u_status (
        .clk(clk), .rst(rst), .set(st_set), .clr(clr), .q(st_q)
    );

    adc_alarm_sticky #(.N(FLAG_N)) u_pending (
        .clk(clk), .rst(rst), .set(pd_set), .clr(clr), .q(pd_q)
    );

    assign irq       = |pd_q;
    assign stat_done = st_q.eoc;
    assign stat_hi   = st_q.up;
    assign stat_lo   = st_q.dn;

    always_comb begin
        case (reg_addr)
            REG_TH_UP:  reg_rdata = th_up;
            REG_TH_DN:  reg_rdata = th_dn;
            REG_STATUS: reg_rdata = TH_W'(st_q);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_alarm_checker.sv
module adc_alarm_checker
#(
    parameter int BYTE_W = 8,
    parameter int TH_W   = 8
)
(
    input logic              clk,
    input logic              rst,
    input logic              adc_en,
    input logic              hi_en,
    input logic              lo_en,
    input logic              conv_done,
    input logic [BYTE_W-1:0] sample_hi,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [TH_W-1:0]   reg_wdata,
    input logic              irq,
    input logic              stat_done,
    input logic              stat_hi,
    input logic              stat_lo
);
    logic stat_wr;
    assign stat_wr = reg_we && (reg_addr == 2'd2);

    assert_neg_sets_low_R3: assert property (@(posedge clk) disable iff (rst)
        conv_done && sample_hi[BYTE_W-1] |=> stat_lo);

    assert_done_every_conv_R4: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> stat_done);

    assert_hi_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        stat_hi && !(stat_wr && reg_wdata[1]) |=> stat_hi);

    assert_eoc_irq_R6: assert property (@(posedge clk) disable iff (rst)
        conv_done && adc_en && !hi_en && !lo_en |=> irq);

    assert_no_new_irq_R8: assert property (@(posedge clk) disable iff (rst)
        !adc_en && !irq |=> !irq);

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (rst)
        stat_wr && (reg_wdata[2:0] == 3'b111) && !conv_done |=> !irq);
endmodule

bind adc_alarm_top adc_alarm_checker #(.BYTE_W(BYTE_W), .TH_W(TH_W)) u_chk (.*);

// File: tb/adc_alarm_top_bench.sv
module adc_alarm_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_en = 0, hi_en = 0, lo_en = 0, conv_done = 0;
    logic [7:0] sample_hi = 0, sample_lo = 0;
    logic       reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq, stat_done, stat_hi, stat_lo;

    int    checks = 0, fails = 0;
    string cur = "R1";
    bit    finished = 0;

    always #10 clk = ~clk;

    adc_alarm_top u_adc_alarm_top (.*);

    // behavioural reference model
    int m_up = 255, m_dn = 0;
    bit m_sd, m_sh, m_sl, m_pd, m_ph, m_pl;

    always @(posedge clk) begin
        int  win;
        bit  neg, hc, lc;
        bit [2:0] c;
        if (rst) begin
            m_up = 255; m_dn = 0;
            {m_sd, m_sh, m_sl, m_pd, m_ph, m_pl} = '0;
        end else begin
            neg = sample_hi[7];
            win = {sample_hi[6:0], sample_lo[7]};
            hc  = conv_done && !neg && (win > m_up);
            lc  = conv_done && (neg || (win < m_dn));
            c   = (reg_we && reg_addr == 2) ? reg_wdata[2:0] : 3'b000;
            m_sd = conv_done || (m_sd && !c[0]);
            m_sh = hc || (m_sh && !c[1]);
            m_sl = lc || (m_sl && !c[2]);
            m_pd = (conv_done && adc_en && !hi_en && !lo_en) || (m_pd && !c[0]);
            m_ph = (hc && adc_en && hi_en) || (m_ph && !c[1]);
            m_pl = (lc && adc_en && lo_en) || (m_pl && !c[2]);
            if (reg_we && reg_addr == 0) m_up = reg_wdata;
            if (reg_we && reg_addr == 1) m_dn = reg_wdata;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return 8'(m_up);
            2'd1: return 8'(m_dn);
            2'd2: return {5'b0, m_sl, m_sh, m_sd};
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare();
        logic [3:0] got, exp;
        got = {irq, stat_lo, stat_hi, stat_done};
        exp = {m_pd | m_ph | m_pl, m_sl, m_sh, m_sd};
        checks++;
        if (got !== exp || reg_rdata !== exp_rd(reg_addr)) begin
            fails++;
            $display("FAIL %s: {irq,lo,hi,done}=%b rdata=%h expected %b rdata=%h",
                     cur, got, reg_rdata, exp, exp_rd(reg_addr));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic conv(input bit neg, input logic [7:0] win);
        {sample_hi, sample_lo} = {neg, win, 7'h55};
        conv_done = 1;
        tick();
        conv_done = 0;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 0; reg_addr = 2;
        tick();
    endtask

    task automatic look(input logic [1:0] a);
        reg_addr = a;
        #1 compare();
        reg_addr = 2;
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        cur = "R1"; compare();
        rst = 0;
        tick();
        cur = "R10"; look(0); look(1); look(2); look(3);

        // R4: status set with all enables off, no irq
        cur = "R4"; conv(0, 8'h80);
        // R6: end-of-conversion interrupt
        adc_en = 1;
        cur = "R6"; conv(0, 8'h40);
        cur = "R9"; wr(2, 8'h01);
        cur = "R5"; wr(2, 8'h00);

        // R10: limits write and readback
        cur = "R10"; wr(0, 8'h80); wr(1, 8'h20); look(0); look(1);

        // R2: equality is not over, one above is
        hi_en = 1;
        cur = "R2"; conv(0, 8'h80);
        cur = "R6"; conv(0, 8'h50);
        cur = "R7"; conv(0, 8'h81);
        cur = "R9"; wr(2, 8'h02);

        // R3: lower edge and sign rules
        lo_en = 1; hi_en = 0;
        cur = "R3"; conv(0, 8'h20);
        cur = "R3"; conv(0, 8'h1F);
        wr(2, 8'h07);
        wr(0, 8'h00);
        cur = "R3"; conv(1, 8'hFF);
        look(2);
        wr(2, 8'h07);

        // R8: disabled converter
        hi_en = 1; lo_en = 1; adc_en = 0;
        cur = "R8"; conv(1, 8'h00);
        wr(2, 8'h07);
        adc_en = 1;
        cur = "R7"; conv(0, 8'h10);
        adc_en = 0;
        cur = "R8"; tick(); tick(); conv(0, 8'h10);

        // R5: set and clear same cycle, set wins
        cur = "R5";
        {sample_hi, sample_lo} = {1'b0, 8'h90, 7'h0};
        conv_done = 1; reg_we = 1; reg_addr = 2; reg_wdata = 8'h07;
        tick();
        conv_done = 0; reg_we = 0;
        tick();
        // R9: partial clear keeps irq
        cur = "R9"; wr(2, 8'h02); wr(2, 8'h04); wr(2, 8'h01);

        // random mix
        cur = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            adc_en = r[0]; hi_en = r[1]; lo_en = r[2];
            conv_done = r[3] & r[4];
            sample_hi = r[15:8]; sample_lo = r[23:16];
            reg_we = r[5] & r[6] & r[7];
            reg_addr = r[25:24];
            reg_wdata = r[31:24];
            if (r[26]) cur = "R7"; else cur = "R2";
            tick();
        end
        reg_we = 0; conv_done = 0;
        tick();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule